// File: doc/BRIEF.md
# Framebuffer Control and Status Register Window

This block is the register file of a simple framebuffer controller. It occupies a 32-byte window on a byte-wide, byte-addressed bus. The window holds a control byte, a status byte and fourteen general-purpose byte registers. The block also drives one level-sensitive interrupt request that reports the end of each video frame. Software turns the interrupt on through the top bit of the control byte. Once raised, the request stays up until software writes the status byte.

Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle and has no side effects. A write is applied at the rising clock edge on which `bus_wr` is high. The lower half of the window (offsets 0x00 to 0x0F) belongs to a colour palette that lives elsewhere. Here those offsets are only decoded: they read as zero and writes to them are dropped. Video timing comes from outside the block as the single-cycle strobe `frame_end`.

Top module: `fbc_regs`

## Requirements
- R1: After a synchronous active-low reset, `irq` is low and the control byte and every general-purpose byte read as 0x00. Status reads as 0x61.
- R2: The control byte at offset 0x10 reads back exactly the last value written to it, for all 256 values.
- R3: If `frame_end` is high on an edge while control bit 7 holds 1, the pending flag is set. From the next cycle `irq` is high and status at offset 0x11 reads 0xE1.
- R4: If `frame_end` is high on an edge while control bit 7 holds 0, nothing changes: `irq` stays low and status reads 0x61.
- R5: A write of any data value to offset 0x11 clears the pending flag, so `irq` is low and status reads 0x61 from the next cycle.
- R6: If a status write and an enabled `frame_end` fall on the same edge, the pending flag ends up set and `irq` is high.
- R7: The pending flag is sticky. Clearing control bit 7, or reading any register, leaves it and `irq` unchanged.
- R8: Offsets 0x12 through 0x1F are fourteen independent byte registers, each reading back the last value written to it.
- R9: Offsets 0x00 through 0x0F read 0x00, and writes there change no register and do not affect `irq`.
- R10: Status bits 6..0 always read as the fixed identification code 0x61. Bits 6 and 5 form the monitor sense code and bit 0 flags a colour board. Data written to status is never stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| frame_end | input | 1 | One-cycle end-of-frame strobe |
| irq | output | 1 | Level interrupt request, high while pending |

## Verification
The bench goes after the collision of a status write with an enabled frame strobe. A design that let the clear win there would silently lose a frame interrupt. It checks that writing status with zero data still clears the flag, which catches a design that clears only on a written 1 in bit 7. It also checks that turning the enable off does not drop a request already pending. Full sweeps over the control byte and the general-purpose bank, together with writes into the palette half of the window, expose offset-decode faults that alias one register onto another or let a palette write land in a real register.

// File: rtl/fbc_regs_pkg.sv
// Package: shared offsets and constants for the framebuffer register window.
// Assumes a 5-bit byte offset and byte-wide data.
package fbc_regs_pkg;
    localparam int FBC_ADDR_W   = 5;
    localparam int FBC_DATA_W   = 8;
    localparam int OFF_CTRL     = 'h10;
    localparam int OFF_STAT     = 'h11;
    localparam int OFF_GP_FIRST = 'h12;
    localparam int OFF_GP_LAST  = 'h1F;
    localparam int GP_COUNT     = OFF_GP_LAST - OFF_GP_FIRST + 1;
    localparam int IRQ_EN_BIT   = 7;
    localparam int PEND_BIT     = 7;
    localparam logic [7:0] STAT_ID = 8'h61;
endpackage

// File: rtl/fbc_ctrl_reg.sv
// Module: control byte. Stores whatever the bus writes at its offset and
// exposes the frame interrupt enable. Assumes a synchronous active-low reset.
module fbc_ctrl_reg #(
    parameter int DATA_W = 8,
    parameter int EN_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic              irq_en
);
    // Capture the control byte on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    assign irq_en = q[EN_BIT];

    // R2
    ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(wdata));
endmodule

// File: rtl/fbc_irq_status.sv
// Module: sticky frame-end pending flag and the interrupt line. A frame-end
// with the enable set raises the flag. Any status write clears it, and the
// set wins when both land on the same edge.
module fbc_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic irq_en,
    input  logic stat_we,
    output logic pending
);
    logic set_req;

    assign set_req = frame_end && irq_en;

    // Update the pending flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (set_req) pending <= 1'b1;
        else if (stat_we) pending <= 1'b0;
    end

    // R3 R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && irq_en) |=> pending);
    // R5
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !(frame_end && irq_en)) |=> !pending);
    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_we && !(frame_end && irq_en)) |=> $stable(pending));
endmodule

// File: rtl/fbc_byte_bank.sv
// Module: bank of plain read/write byte registers at consecutive offsets.
// Assumes the bank sits at BASE..BASE+COUNT-1 inside the window.
module fbc_byte_bank #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int BASE   = 'h12,
    parameter int COUNT  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              hit
);
    logic [DATA_W-1:0] regs [COUNT];
    logic [COUNT-1:0]  sel;

    for (genvar i = 0; i < COUNT; i++) begin : g_reg
        assign sel[i] = (addr == ADDR_W'(BASE + i));

        // Store one byte when it is written.
        always_ff @(posedge clk) begin
            if (!rst_n)              regs[i] <= '0;
            else if (we && sel[i])   regs[i] <= wdata;
        end

        // R8
        bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel[i]) |=> $stable(regs[i]));
    end

    assign hit = |sel;

    // Select the addressed byte, zero when nothing in the bank is hit.
    always_comb begin
        rdata = '0;
        for (int j = 0; j < COUNT; j++)
            if (sel[j]) rdata = regs[j];
    end

    // R8
    bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/fbc_regs.sv
// Module: top of the framebuffer register window. It decodes the byte
// offset, routes writes to the control, status and general-purpose
// registers, and muxes combinational read data. Palette offsets below 0x10
// are only decoded: they read zero and ignore writes.
module fbc_regs
    import fbc_regs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FBC_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [FBC_DATA_W-1:0] bus_wdata,
    output logic [FBC_DATA_W-1:0] bus_rdata,
    input  logic                  frame_end,
    output logic                  irq
);
    localparam logic [FBC_ADDR_W-1:0] A_CTRL = FBC_ADDR_W'(OFF_CTRL);
    localparam logic [FBC_ADDR_W-1:0] A_STAT = FBC_ADDR_W'(OFF_STAT);

    logic                  hit_ctrl, hit_stat, hit_gp;
    logic [FBC_DATA_W-1:0] ctrl_q, gp_rdata, stat_rd;
    logic                  irq_en, pending;

    assign hit_ctrl = (bus_addr == A_CTRL);
    assign hit_stat = (bus_addr == A_STAT);

    fbc_ctrl_reg #(.DATA_W(FBC_DATA_W), .EN_BIT(IRQ_EN_BIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && hit_ctrl),
        .wdata(bus_wdata), .q(ctrl_q), .irq_en(irq_en));

    fbc_irq_status u_stat (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .irq_en(irq_en),
        .stat_we(bus_wr && hit_stat), .pending(pending));

    fbc_byte_bank #(.ADDR_W(FBC_ADDR_W), .DATA_W(FBC_DATA_W),
                    .BASE(OFF_GP_FIRST), .COUNT(GP_COUNT)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(gp_rdata), .hit(hit_gp));

    assign irq = pending;

    // Merge the fixed identification code with the pending flag.
    always_comb begin
        stat_rd = STAT_ID;
        stat_rd[PEND_BIT] = pending;
    end

    // Read data mux; palette and unmapped offsets read zero.
    always_comb begin
        if (hit_ctrl)      bus_rdata = ctrl_q;
        else if (hit_stat) bus_rdata = stat_rd;
        else if (hit_gp)   bus_rdata = gp_rdata;
        else               bus_rdata = '0;
    end

    // R9
    low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr[FBC_ADDR_W-1] |-> bus_rdata == '0);
    // R10
    stat_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_stat |-> bus_rdata[6:0] == STAT_ID[6:0]);
    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(frame_end) && $past(ctrl_q[IRQ_EN_BIT]));
endmodule

// File: tb/fbc_regs_tb.sv
module fbc_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       frame_end = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_gp [14];

    always #2 clk = ~clk;

    fbc_regs u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_end(frame_end), .irq(irq));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, input string req, input logic [7:0] exp);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // Inputs are set at a falling edge and applied at the next rising edge.
    task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic fe = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; frame_end = fe;
        @(negedge clk);
        bus_wr = 1'b0; frame_end = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(5'h10, "R1 ctrl", 8'h00);
        rd(5'h11, "R1 stat", 8'h61);
        for (int a = 'h12; a <= 'h1F; a++) rd(5'(a), "R1 gp", 8'h00);

        // R2 control sweep over all values
        for (int v = 0; v < 256; v++) begin
            wr(5'h10, 8'(v));
            rd(5'h10, "R2 ctrl", 8'(v));
        end

        // R4 frame with enable clear
        wr(5'h10, 8'h7F);
        frame();
        check("R4 irq", {7'b0, irq}, 8'h00);
        rd(5'h11, "R4 stat", 8'h61);

        // R3 frame with enable set
        wr(5'h10, 8'h80);
        frame();
        check("R3 irq", {7'b0, irq}, 8'h01);
        rd(5'h11, "R3 stat", 8'hE1);

        // R7 sticky through enable clear and reads
        wr(5'h10, 8'h00);
        rd(5'h10, "R7 ctrl", 8'h00);
        rd(5'h11, "R7 stat", 8'hE1);
        repeat (3) @(negedge clk);
        check("R7 irq", {7'b0, irq}, 8'h01);

        // R5 clear with zero data, then with all ones
        wr(5'h11, 8'h00);
        check("R5 irq zero-data", {7'b0, irq}, 8'h00);
        rd(5'h11, "R5 stat", 8'h61);
        wr(5'h10, 8'h80);
        frame();
        wr(5'h11, 8'hFF);
        check("R5 irq ones-data", {7'b0, irq}, 8'h00);
        // R10 written data not stored
        rd(5'h11, "R10 stat", 8'h61);
        rd(5'h10, "R10 ctrl kept", 8'h80);

        // R6 collision: set wins
        wr(5'h11, 8'h80, 1'b1);
        check("R6 irq", {7'b0, irq}, 8'h01);
        rd(5'h11, "R6 stat", 8'hE1);
        wr(5'h11, 8'h00);
        check("R6 cleared after", {7'b0, irq}, 8'h00);

        // R8 general-purpose bank, two patterns
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 14; i++) begin
                exp_gp[i] = 8'((i * 17 + 3) ^ (p * 8'hA5));
                wr(5'('h12 + i), exp_gp[i]);
            end
            for (int i = 0; i < 14; i++) rd(5'('h12 + i), "R8 gp", exp_gp[i]);
        end

        // R9 palette half: reads zero, writes ignored
        wr(5'h10, 8'h80);
        for (int a = 0; a < 16; a++) begin
            wr(5'(a), 8'hFF);
            rd(5'(a), "R9 low read", 8'h00);
        end
        rd(5'h10, "R9 ctrl kept", 8'h80);
        rd(5'h11, "R9 stat kept", 8'h61);
        check("R9 irq", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 14; i++) rd(5'('h12 + i), "R9 gp kept", exp_gp[i]);

        // R1 reset again clears pending and registers
        frame();
        check("R3 irq again", {7'b0, irq}, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        rd(5'h10, "R1 ctrl after reset", 8'h00);
        rd(5'h12, "R1 gp after reset", 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule